// File: doc/BRIEF.md
# Snapshot-Read 64-bit Up-Counter

This block keeps a free-running 64-bit up-counter that advances once per cycle of its clock, the timer source clock, nominally 24 MHz. Software cannot read the live value. Instead it takes a coherent copy of it. Software writes a request bit in a control word. The block copies the counter into a snapshot register a fixed number of cycles later, and drops the request bit in the same cycle. Software polls the control word until the bit reads zero, then fetches the two 32-bit halves of the snapshot from their own offsets. The two halves always come from the same count.

The register port is a plain synchronous write strobe with a combinational read. Reads never change state. The snapshot keeps its value until the next accepted request. The counter width and the request-to-capture latency are parameters. The default width of 64 keeps the high half meaningful. A narrow width exists so the wrap can be reached in a short run.

Top module: `latched_counter64`

## Requirements
- R1: After reset the counter is zero and the control word, the low half and the high half all read zero.
- R2: The counter advances by one on every clock edge after reset. A request written at edge T captures the value the counter holds just before edge T+LATCH_DELAY. That value equals the count visible when the write was presented, plus LATCH_DELAY.
- R3: The request is bit 1 of the control word at offset 0xA0. It reads 1 after the accepting edge and keeps reading 1 until the capture edge, when it returns to 0 in the same cycle the snapshot loads.
- R4: Offset 0xA4 returns snapshot bits 31:0 and offset 0xA8 returns bits 63:32. A counter narrower than 64 bits is zero-extended.
- R5: The snapshot holds its value until the next accepted request, and reading any offset changes no state.
- R6: A request written while one is pending, up to and including its capture cycle, is ignored. The capture happens at the original time with the original value.
- R7: A control write with bit 1 clear starts nothing. Every control bit other than bit 1 reads zero. Writes to 0xA4 or 0xA8 leave the snapshot unchanged.
- R8: The counter wraps from all ones to zero.
- R9: Offsets other than 0xA0, 0xA4 and 0xA8 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer source clock; the counter advances on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte offset for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The hardest situation to reach is a second request that lands while a capture is still in flight. If it restarted the delay, the snapshot would come out one count late, and that would only show in the value read back. The stimulus therefore issues two back-to-back control writes and checks the snapshot against the count at the first write. A second case checks the wrap. A narrow-width instance shares the same bus, and the stimulus times a request so that its capture falls exactly on the all-ones count, followed by one just after the rollover.

// File: rtl/latched_counter64.sv
module latched_counter64 #(
  parameter int CNT_W       = 64,
  parameter int LATCH_DELAY = 2,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int DLY_W = $clog2(LATCH_DELAY + 1);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8'hA0);
  localparam logic [ADDR_W-1:0] OFS_LO   = ADDR_W'(8'hA4);
  localparam logic [ADDR_W-1:0] OFS_HI   = ADDR_W'(8'hA8);
  localparam int REQ_BIT = 1;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] snap;
  logic [63:0]      snap_ext;
  logic             pend;
  logic [DLY_W-1:0] dly;
  logic             req_wr;
  logic             cap;

  assign req_wr   = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[REQ_BIT];
  assign cap      = pend && (dly == '0);
  assign snap_ext = 64'(snap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      snap  <= '0;
      pend  <= 1'b0;
      dly   <= '0;
    end else begin
      count <= count + 1'b1;
      if (cap) begin
        snap <= count;
        pend <= 1'b0;
      end else if (pend) begin
        dly <= dly - 1'b1;
      end else if (req_wr) begin
        pend <= 1'b1;
        dly  <= DLY_W'(LATCH_DELAY - 1);
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = 32'(pend) << REQ_BIT;
      OFS_LO:   bus_rdata = snap_ext[31:0];
      OFS_HI:   bus_rdata = snap_ext[63:32];
      default:  bus_rdata = '0;
    endcase
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count == $past(count) + 1'b1);

  assert_capture_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> snap == $past(count));

  assert_pend_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !pend && bus_rdata[REQ_BIT] == 1'b0 || bus_addr != OFS_CTRL);

  assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend && dly != '0 |=> pend && dly == $past(dly) - 1'b1);

  assert_snap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(snap));

  assert_ctrl_spare_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == OFS_CTRL |-> bus_rdata[31:2] == '0 && bus_rdata[0] == 1'b0);

endmodule

// File: tb/latched_counter64_test.sv
`timescale 1ns/1ps
module latched_counter64_test;
  localparam int LD = 2;
  localparam int SW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_main, rd_small;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] mdl = '0;

  logic [31:0] expm_q[$];
  logic [31:0] exps_q[$];
  string       tag_q[$];
  logic        mon_go = 1'b0;

  always #4 clk = ~clk;

  latched_counter64 #(.CNT_W(64), .LATCH_DELAY(LD), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_main));

  latched_counter64 #(.CNT_W(SW), .LATCH_DELAY(LD), .ADDR_W(8)) uut_small (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_small));

  always @(posedge clk) if (rst_n) mdl <= mdl + 1;

  always @(negedge clk) begin
    if (mon_go && expm_q.size() > 0) begin
      logic [31:0] em, es;
      string t;
      em = expm_q.pop_front();
      es = exps_q.pop_front();
      t  = tag_q.pop_front();
      checks += 2;
      if (rd_main !== em) begin
        errors++;
        $display("FAIL %s main addr=%h actual=%h expected=%h", t, bus_addr, rd_main, em);
      end
      if (rd_small !== es) begin
        errors++;
        $display("FAIL %s narrow addr=%h actual=%h expected=%h", t, bus_addr, rd_small, es);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] em, input logic [31:0] es, input string t);
    bus_addr = a;
    expm_q.push_back(em);
    exps_q.push_back(es);
    tag_q.push_back(t);
    mon_go = 1'b1;
    step();
    mon_go = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic snap_check(input logic [63:0] exp, input string t);
    logic [63:0] es;
    es = exp & ((64'd1 << SW) - 1);
    rd(8'hA4, exp[31:0], es[31:0], t);
    rd(8'hA8, exp[63:32], es[63:32], t);
  endtask

  task automatic request(output logic [63:0] exp);
    exp = mdl + LD;
    wr(8'hA0, 32'h2);
    for (int j = 0; j < LD; j++) rd(8'hA0, 32'h2, 32'h2, "R3 pending");
    rd(8'hA0, 32'h0, 32'h0, "R3 cleared");
  endtask

  initial begin
    logic [63:0] e, e2;
    step(); step();
    rst_n = 1'b1;
    rd(8'hA0, 0, 0, "R1 ctrl");
    rd(8'hA4, 0, 0, "R1 lo");
    rd(8'hA8, 0, 0, "R1 hi");

    repeat (7) step();
    request(e);
    snap_check(e, "R2 R4 first");
    repeat (13) step();
    request(e2);
    snap_check(e2, "R2 second");
    if (e2 <= e) begin checks++; errors++; $display("FAIL R2 actual=%0d expected>%0d", e2, e); end
    else checks++;

    repeat (50) step();
    snap_check(e2, "R5 hold");
    snap_check(e2, "R5 reread");

    e = mdl + LD;
    wr(8'hA0, 32'h2);
    wr(8'hA0, 32'h2);
    rd(8'hA0, 32'h2, 32'h2, "R6 pending");
    rd(8'hA0, 32'h0, 32'h0, "R6 cleared");
    snap_check(e, "R6 original time");

    wr(8'hA0, 32'hFFFF_FFFD);
    rd(8'hA0, 0, 0, "R7 no request");
    wr(8'hA4, 32'hDEAD_BEEF);
    wr(8'hA8, 32'h1234_5678);
    repeat (5) step();
    snap_check(e, "R7 snapshot untouched");
    rd(8'h10, 0, 0, "R9 unmapped");
    rd(8'hA1, 0, 0, "R9 unmapped odd");

    while ((mdl & 64'hFFF) != 64'd4093) step();
    request(e);
    snap_check(e, "R8 all ones");
    request(e2);
    snap_check(e2, "R8 after wrap");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule